// File: doc/BRIEF.md
# Radix-2-Squared Feedback Butterfly Pair

This block is the first radix-4 step of a pipelined, single-path delay-feedback FFT. It takes one complex sample per accepted clock in natural order. Two radix-2 butterflies, each with its own feedback delay line, turn every N-point frame into four interleaved radix-4 partial sums. The delay of the first butterfly is N/2 and that of the second is N/4.

The multiplication by -j that a radix-4 step needs is done inside the second butterfly. The real and imaginary parts are swapped and one sign is flipped, so the pair needs no multiplier. A later twiddle multiplier, output reordering and scaling are left to the stages that follow.

One free-running sample counter drives both butterflies. It advances only on accepted samples, so the input may pause at any time without disturbing frame alignment. Frame position 0 is the first sample accepted after reset.

Top module: `r22_pair`

## Requirements
- R1: While reset is high, and after it until the first output is due, `out_valid` is 0 and both output components are 0.
- R2: The first `out_valid` pulse comes with the (3N/4+2)-th accepted input sample. From then on, every accepted sample produces exactly one output.
- R3: Let a frame hold x[0..N-1] and M = N/4. Output positions 0..M-1 of the frame give, for m = position, x[m]+x[m+M]+x[m+2M]+x[m+3M].
- R4: Positions M..2M-1 give, for m = position-M, x[m]-x[m+M]+x[m+2M]-x[m+3M].
- R5: Positions 2M..3M-1 give, for m = position-2M, (x[m]-x[m+2M]) - j(x[m+M]-x[m+3M]). The real part is dre+eim and the imaginary part is dim-ere, where d = x[m]-x[m+2M] and e = x[m+M]-x[m+3M].
- R6: Positions 3M..N-1 give (x[m]-x[m+2M]) + j(x[m+M]-x[m+3M]), with m = position-3M.
- R7: Inputs are two's complement, DW bits per component. Outputs are two's complement, DW+2 bits, and exact: full-scale inputs of either sign never wrap.
- R8: A cycle with `in_valid` low advances nothing. The next `out_valid` is 0 and both output components keep their values.
- R9: Frames run back to back without gaps or leakage. After K·N accepted samples, exactly K·N-(3N/4+1) outputs have appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output sample present |
| out_re | output | DW+2 | Output real part, signed |
| out_im | output | DW+2 | Output imaginary part, signed |

## Verification
A wrong control bit or a misaligned counter mixes samples across quarters of a frame. That shows up as wrong sums in the first output block after the pipeline fills, about 3N/4 samples after the fault. A missing rotation or a wrong rotation sign changes only the last two output blocks. Impulse and asymmetric frames make it visible within half a frame of output. A stale delay entry leaks into the next frame, so back-to-back frames with different content expose it. A stall that advances state misaligns every later output.

// File: rtl/r22_pkg.sv
package r22_pkg;

    typedef enum logic {
        MODE_FILL    = 1'b0,
        MODE_COMBINE = 1'b1
    } bf_mode_e;

    typedef struct packed {
        bf_mode_e mode;
        logic     rot;
    } bf_ctrl_t;

    // Decode butterfly control from a frame position.
    // second=0: first butterfly, combines in the upper half of the frame.
    // second=1: second butterfly, combines in odd quarters and rotates
    //           by -j in the second quarter of its own counter.
    function automatic bf_ctrl_t ctrl_of(input logic [31:0] idx,
                                         input int unsigned lg,
                                         input logic second);
        bf_ctrl_t c;
        logic hi;
        logic lo;
        hi = idx[lg-1];
        lo = idx[lg-2];
        if (!second) begin
            c.mode = hi ? MODE_COMBINE : MODE_FILL;
            c.rot  = 1'b0;
        end else begin
            c.mode = lo ? MODE_COMBINE : MODE_FILL;
            c.rot  = ~hi & lo;
        end
        return c;
    endfunction

endpackage

// File: rtl/r22_delay.sv
module r22_delay #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0][WIDTH-1:0] sr;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)     sr[0] <= '0;
                else if (en) sr[0] <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else if (en) begin
                    sr[0] <= din;
                    for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
                end
            end
        end
    endgenerate

    assign dout = sr[DEPTH-1];
endmodule

// File: rtl/r22_seq.sv
module r22_seq
    import r22_pkg::*;
#(
    parameter int FFT_N = 256
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    output bf_ctrl_t ctrl_a,
    output bf_ctrl_t ctrl_b,
    output logic     out_valid
);
    localparam int LG   = $clog2(FFT_N);
    localparam int FILL = 3 * FFT_N / 4 + 1;

    logic [LG-1:0] cnt;
    logic [LG-1:0] cnt_d;
    logic [LG:0]   warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            cnt_d     <= '0;
            warm      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= en && (warm == (LG+1)'(FILL));
            if (en) begin
                cnt   <= cnt + 1'b1;
                cnt_d <= cnt;
                if (warm != (LG+1)'(FILL)) warm <= warm + 1'b1;
            end
        end
    end

    assign ctrl_a = ctrl_of(32'(cnt), LG, 1'b0);
    assign ctrl_b = ctrl_of(32'(cnt_d), LG, 1'b1);

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == {LG{1'b1}}) |=> (cnt == '0)); // R9
endmodule

// File: rtl/r22_bf.sv
module r22_bf
    import r22_pkg::*;
#(
    parameter int IW     = 9,
    parameter int DEPTH  = 128,
    parameter bit ROTATE = 1'b0,
    localparam int OW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  bf_ctrl_t      ctrl,
    input  logic [IW-1:0] in_re,
    input  logic [IW-1:0] in_im,
    output logic [OW-1:0] out_re,
    output logic [OW-1:0] out_im
);
    logic [OW-1:0] x_re, x_im;
    logic [OW-1:0] a_re, a_im;
    logic [OW-1:0] fd_re, fd_im;
    logic [OW-1:0] fi_re, fi_im;
    logic [OW-1:0] y_re, y_im;

    assign x_re = {{(OW-IW){in_re[IW-1]}}, in_re};
    assign x_im = {{(OW-IW){in_im[IW-1]}}, in_im};

    generate
        if (ROTATE) begin : g_rot
            always_comb begin
                if (ctrl.rot) begin
                    a_re = x_im;
                    a_im = -x_re;
                end else begin
                    a_re = x_re;
                    a_im = x_im;
                end
            end
        end else begin : g_plain
            assign a_re = x_re;
            assign a_im = x_im;
        end
    endgenerate

    always_comb begin
        if (ctrl.mode == MODE_COMBINE) begin
            y_re  = fd_re + a_re;
            y_im  = fd_im + a_im;
            fi_re = fd_re - a_re;
            fi_im = fd_im - a_im;
        end else begin
            y_re  = fd_re;
            y_im  = fd_im;
            fi_re = a_re;
            fi_im = a_im;
        end
    end

    r22_delay #(.WIDTH(2*OW), .DEPTH(DEPTH)) u_fb (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .din  ({fi_re, fi_im}),
        .dout ({fd_re, fd_im})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_re <= '0;
            out_im <= '0;
        end else if (en) begin
            out_re <= y_re;
            out_im <= y_im;
        end
    end

    // On combine the delay line must hold an unmodified earlier input.
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (en && ctrl.mode == MODE_COMBINE) |->
        (((fd_re[OW-1:IW-1] == '0) || (&fd_re[OW-1:IW-1])) &&
         ((fd_im[OW-1:IW-1] == '0) || (&fd_im[OW-1:IW-1])))); // R7
endmodule

// File: rtl/r22_pair.sv
module r22_pair
    import r22_pkg::*;
#(
    parameter int FFT_N = 256,
    parameter int DW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    output logic [DW+1:0] out_re,
    output logic [DW+1:0] out_im
);
    localparam int D_A = FFT_N / 2;
    localparam int D_B = FFT_N / 4;

    bf_ctrl_t      ctrl_a, ctrl_b;
    logic [DW:0]   mid_re, mid_im;

    r22_seq #(.FFT_N(FFT_N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (in_valid),
        .ctrl_a    (ctrl_a),
        .ctrl_b    (ctrl_b),
        .out_valid (out_valid)
    );

    r22_bf #(.IW(DW), .DEPTH(D_A), .ROTATE(1'b0)) u_bf_a (
        .clk    (clk),
        .rst    (rst),
        .en     (in_valid),
        .ctrl   (ctrl_a),
        .in_re  (in_re),
        .in_im  (in_im),
        .out_re (mid_re),
        .out_im (mid_im)
    );

    r22_bf #(.IW(DW+1), .DEPTH(D_B), .ROTATE(1'b1)) u_bf_b (
        .clk    (clk),
        .rst    (rst),
        .en     (in_valid),
        .ctrl   (ctrl_b),
        .in_re  (mid_re),
        .in_im  (mid_im),
        .out_re (out_re),
        .out_im (out_im)
    );

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R8

    AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_re) && $stable(out_im) && !out_valid)); // R8
endmodule

// File: tb/r22_pair_tb.sv
module r22_pair_tb_top;
    localparam int N   = 256;
    localparam int W   = 9;
    localparam int M   = N / 4;
    localparam int MAXV = (1 << (W-1)) - 1;
    localparam int MINV = -(1 << (W-1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_re = '0;
    logic [W-1:0]  in_im = '0;
    logic          out_valid;
    logic [W+1:0]  out_re, out_im;

    always #2 clk = ~clk;

    r22_pair #(.FFT_N(N), .DW(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    typedef struct { int re; int im; int frame; int pos; bit ext; } item_t;
    item_t sb_q[$];

    int checks = 0;
    int failures = 0;
    int n_acc = 0;
    bit acc_last = 1'b0;
    bit mon_on = 1'b0;
    bit seen = 1'b0;
    bit done = 1'b0;
    int fr_re[N];
    int fr_im[N];
    int frame_no = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic drive_cycle(input bit v, input int re, input int im);
        @(negedge clk);
        in_valid = v;
        in_re = W'(re);
        in_im = W'(im);
        @(posedge clk);
        acc_last = v;
        if (v) n_acc++;
    endtask

    function automatic void expect_at(input int r, output int er, output int ei);
        int b, m, a, bb, c, d;
        b = r / M; m = r % M;
        a = m; bb = m + M; c = m + 2*M; d = m + 3*M;
        case (b)
            0: begin
                er = fr_re[a] + fr_re[bb] + fr_re[c] + fr_re[d];
                ei = fr_im[a] + fr_im[bb] + fr_im[c] + fr_im[d];
            end
            1: begin
                er = fr_re[a] - fr_re[bb] + fr_re[c] - fr_re[d];
                ei = fr_im[a] - fr_im[bb] + fr_im[c] - fr_im[d];
            end
            2: begin
                er = (fr_re[a] - fr_re[c]) + (fr_im[bb] - fr_im[d]);
                ei = (fr_im[a] - fr_im[c]) - (fr_re[bb] - fr_re[d]);
            end
            default: begin
                er = (fr_re[a] - fr_re[c]) - (fr_im[bb] - fr_im[d]);
                ei = (fr_im[a] - fr_im[c]) + (fr_re[bb] - fr_re[d]);
            end
        endcase
    endfunction

    task automatic drive_frame(input int kind, input int gap_every);
        item_t it;
        for (int i = 0; i < N; i++) begin
            int q;
            q = i / M;
            case (kind)
                0: begin fr_re[i] = (i == 5) ? 100 : 0; fr_im[i] = (i == 5) ? -37 : 0; end
                1: begin fr_re[i] = 50; fr_im[i] = -20; end
                2: begin fr_re[i] = MAXV; fr_im[i] = MAXV; end
                3: begin
                    fr_re[i] = (q == 0 || q == 3) ? MAXV : MINV;
                    fr_im[i] = (q == 0 || q == 3) ? MINV : MAXV;
                end
                4: begin fr_re[i] = (i % 64) - 32; fr_im[i] = 20 - (i % 41); end
                8: begin fr_re[i] = 0; fr_im[i] = 0; end
                default: begin
                    fr_re[i] = int'($urandom_range(0, 2*MAXV+1)) + MINV;
                    fr_im[i] = int'($urandom_range(0, 2*MAXV+1)) + MINV;
                end
            endcase
        end
        for (int r = 0; r < N; r++) begin
            int er, ei;
            expect_at(r, er, ei);
            it.re = er; it.im = ei; it.frame = frame_no; it.pos = r;
            it.ext = (kind == 2 || kind == 3);
            sb_q.push_back(it);
        end
        for (int i = 0; i < N; i++) begin
            if (gap_every > 0 && (i % gap_every) == gap_every - 1)
                drive_cycle(1'b0, 0, 0);
            drive_cycle(1'b1, fr_re[i], fr_im[i]);
        end
        frame_no++;
    endtask

    // Monitor: scoreboard compare away from the active edge
    initial begin
        int prev_re, prev_im;
        prev_re = 0; prev_im = 0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (out_valid) begin
                    if (!seen) begin
                        seen = 1'b1;
                        chk(n_acc == 3*M + 2, "R2 first output latency", n_acc, 3*M + 2);
                    end
                    chk(acc_last, "R8 output without accepted input", int'(acc_last), 1);
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected extra output", 1, 0);
                    end else begin
                        item_t it;
                        string tag;
                        int ar, ai;
                        it = sb_q.pop_front();
                        ar = int'($signed(out_re));
                        ai = int'($signed(out_im));
                        case (it.pos / M)
                            0: tag = "R3 block sum";
                            1: tag = "R4 block alternating";
                            2: tag = "R5 block minus-j";
                            default: tag = "R6 block plus-j";
                        endcase
                        if (it.ext) tag = {tag, " R7 full scale"};
                        chk(ar == it.re, {tag, " real"}, ar, it.re);
                        chk(ai == it.im, {tag, " imag"}, ai, it.im);
                    end
                end else if (seen) begin
                    chk(int'($signed(out_re)) == prev_re, "R8 real held on idle",
                        int'($signed(out_re)), prev_re);
                    chk(int'($signed(out_im)) == prev_im, "R8 imag held on idle",
                        int'($signed(out_im)), prev_im);
                end
                prev_re = int'($signed(out_re));
                prev_im = int'($signed(out_im));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            finish_up();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(out_re == '0 && out_im == '0, "R1 outputs zero in reset", int'(out_re), 0);
        rst = 1'b0;
        mon_on = 1'b1;
        drive_cycle(1'b0, 0, 0);
        drive_cycle(1'b0, 0, 0);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_re == '0, "R1 idle after reset", int'(out_valid), 0);
        drive_frame(0, 0);
        drive_frame(1, 0);
        drive_frame(2, 0);
        drive_frame(3, 0);
        drive_frame(4, 7);
        drive_frame(5, 0);
        drive_frame(6, 3);
        drive_frame(7, 0);
        drive_frame(8, 0);
        repeat (4) drive_cycle(1'b0, 0, 0);
        // R9: outputs left pending equal the fill depth
        chk(sb_q.size() == 3*M + 1, "R9 pending outputs after stream", sb_q.size(), 3*M + 1);
        done = 1'b1;
        finish_up();
    end
endmodule